// File: doc/BRIEF.md
# Mailbox Request Transmit Sequencer

This block is a hardware requester that pushes one request object into a data-object-exchange mailbox through a 32-bit register port. A client first loads the request payload, one dword at a time, into a small local buffer. It then pulses `start_i` with a vendor identifier, an object type and a payload size in bytes.

The engine polls the mailbox status register until the busy flag clears, or until a cycle-count timeout runs out. It refuses to send if the mailbox reports an error or if the object would be longer than the largest legal object. Otherwise it writes two header dwords and the payload dwords to the write-mailbox register, zero-fills any partial final dword, and writes the go bit to the control register.

Every sequence ends with a one-cycle completion pulse and a two-bit result code. Status reads use a fixed latency: read data is valid in the cycle after the read strobe. Payload dword `i` is taken from buffer entry `i` modulo the buffer depth.

Top module: `mbx_req_sender`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `done_o`, `reg_rd_en_o` and `reg_wr_en_o` are all low.
- R2: After `start_i`, the engine repeatedly reads the status register. No write to the mailbox happens until a status read shows busy (bit `BUSY_BIT`) clear.
- R3: If busy is still set on a status read taken once `TMO_CYC` cycles have elapsed since start, the sequence ends with code 1 and no register write. The completion pulse comes between `TMO_CYC` and `TMO_CYC`+3 cycles after the start edge.
- R4: If the status read that shows busy clear also shows the error bit (bit `ERR_BIT`) set, the sequence ends with code 2 and no write. This takes priority over the oversize check.
- R5: If 2 + ceil(bytes/4) exceeds 2^`LEN_W` dwords, the sequence ends with code 3 and no write.
- R6: The first written dword holds the vendor identifier in bits 15:0, the object type in bits 23:16, and zero in bits 31:24.
- R7: The second written dword holds 2 + ceil(bytes/4) in bits `LEN_W`-1:0, written as 0 when it equals 2^`LEN_W`. All other bits are zero.
- R8: The payload dwords follow the two headers in buffer order, one per cycle. The headers and the payload all go to address `ADDR_WMB`, and there are exactly ceil(bytes/4) payload writes.
- R9: When bytes mod 4 is k ≠ 0, the final payload dword keeps its low k bytes and has its upper bytes zero.
- R10: Exactly one write follows the last data write. It goes to `ADDR_CTRL` with only bit `GO_BIT` set.
- R11: `done_o` is a single-cycle pulse carrying `code_o`. On success it comes in the cycle after the go write, with code 0.
- R12: A `start_i` pulse while `busy_o` is high is ignored: the running object is sent unchanged.
- R13: A status read and a register write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a request (taken only when idle) |
| vendor_i | input | 16 | Protocol vendor identifier |
| objtype_i | input | 8 | Object type |
| nbytes_i | input | BCNT_W | Payload size in bytes |
| pbuf_we_i | input | 1 | Payload buffer write strobe |
| pbuf_addr_i | input | BUF_AW | Payload buffer dword index |
| pbuf_data_i | input | 32 | Payload buffer write data |
| reg_rd_en_o | output | 1 | Status read strobe |
| reg_rd_addr_o | output | ADDR_W | Status read address |
| reg_rd_data_i | input | 32 | Status read data, valid the cycle after the strobe |
| reg_wr_en_o | output | 1 | Register write strobe |
| reg_wr_addr_o | output | ADDR_W | Register write address |
| reg_wr_data_o | output | 32 | Register write data |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | 2 | Result: 0 ok, 1 busy timeout, 2 mailbox error, 3 oversize |

## Verification
The bench is built with a 3-bit length field, so the largest object is 8 dwords. It sweeps the payload size over every byte count from 0 to 40. That covers every tail remainder, the zero-payload case, sizes below, at and above the maximum length, and both the encoded-as-zero and the rejected sizes. A second buffer pattern over the legal sizes shows that the payload comes from the buffer and not from constants.

The mailbox model answers with a few busy reads, with a permanent busy flag, and with the error flag. Each of these is tried on legal and oversized requests. Together they separate the three failure codes and their priority, and they measure when the timeout fires. A restart pulsed in the middle of a send shows that the running object is left unchanged.

// File: rtl/mbx_tx_pkg.sv
// Shared types for the mailbox request transmit sequencer.
// Assumes 32-bit register data; byte 0 is bits 7:0.
package mbx_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_RD,
        ST_POLL_CHK,
        ST_HDR1,
        ST_HDR2,
        ST_PAY,
        ST_GO
    } tx_state_t;

    typedef enum logic [1:0] {
        RC_OK     = 2'd0,
        RC_BUSY   = 2'd1,
        RC_IOERR  = 2'd2,
        RC_TOOBIG = 2'd3
    } tx_code_t;

    // Keep the low 'keep' bytes of a dword; keep==0 means the whole dword.
    function automatic logic [31:0] pad_tail(input logic [31:0] d, input logic [1:0] keep);
        logic [31:0] r;
        case (keep)
            2'd1:    r = {24'h0, d[7:0]};
            2'd2:    r = {16'h0, d[15:0]};
            2'd3:    r = {8'h0, d[23:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbx_len_calc.sv
// Length arithmetic for one request object.
// Works out the payload dword count, the encoded length field and the
// oversize flag from the byte count. Purely combinational.
// Assumes TOT_W > LEN_W so that the total never wraps before comparison.
module mbx_len_calc #(
    parameter int BCNT_W = 21,
    parameter int LEN_W  = 18,
    parameter int TOT_W  = 22
) (
    input  logic [BCNT_W-1:0] nbytes,
    output logic [TOT_W-1:0]  pay_dw,
    output logic [LEN_W-1:0]  len_field,
    output logic              too_big,
    output logic [1:0]        tail
);
    localparam logic [TOT_W-1:0] MAX_DW = TOT_W'(1) << LEN_W;

    logic [TOT_W-1:0] total;

    // Round the byte count up to dwords, add the two header dwords, encode.
    always_comb begin
        pay_dw    = (TOT_W'(nbytes) + TOT_W'(3)) >> 2;
        total     = pay_dw + TOT_W'(2);
        too_big   = total > MAX_DW;
        len_field = total[LEN_W-1:0];
        tail      = nbytes[1:0];
    end

endmodule

// File: rtl/mbx_pay_buf.sv
// Local payload buffer: one write port for the client, one
// combinational read port for the sequencer. Storage has no reset;
// the client loads it before it starts a request.
module mbx_pay_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    // One write decoder per entry.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) mem[g] <= wdata;
        end
    end

    // Read the addressed entry.
    assign rdata = mem[raddr];

endmodule

// File: rtl/mbx_elapsed.sv
// Elapsed-cycle counter for the busy poll. It is held at zero while
// clr is high and counts while en is high, saturating at its maximum.
// expired is high once the count has reached TMO_CYC.
module mbx_elapsed #(
    parameter int TMO_CYC = 1000000,
    parameter int CW      = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          expired
);
    // Advance, clear or hold the elapsed count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         cnt <= '0;
        else if (en && ~&cnt)      cnt <= cnt + CW'(1);
    end

    assign expired = cnt >= CW'(TMO_CYC);

    // R3: once expired, the count stays expired until it is cleared.
    a_r3_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired);

endmodule

// File: rtl/mbx_req_sender.sv
// Mailbox request transmit sequencer (top).
// Polls the status register until busy clears (or times out), checks the
// error bit and the object length, then writes the two header dwords and
// the payload to the write-mailbox register and sets go in control.
// Assumes status read data is valid the cycle after reg_rd_en_o, and that
// BUF_DW is a power of two.
module mbx_req_sender
    import mbx_tx_pkg::*;
#(
    parameter int BCNT_W   = 21,
    parameter int LEN_W    = 18,
    parameter int BUF_DW   = 16,
    parameter int TMO_CYC  = 1000000,
    parameter int ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 12'h008,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 12'h00C,
    parameter logic [ADDR_W-1:0] ADDR_WMB  = 12'h010,
    parameter int BUSY_BIT = 0,
    parameter int ERR_BIT  = 2,
    parameter int GO_BIT   = 31,
    localparam int BUF_AW  = $clog2(BUF_DW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       vendor_i,
    input  logic [7:0]        objtype_i,
    input  logic [BCNT_W-1:0] nbytes_i,
    input  logic              pbuf_we_i,
    input  logic [BUF_AW-1:0] pbuf_addr_i,
    input  logic [31:0]       pbuf_data_i,
    output logic              reg_rd_en_o,
    output logic [ADDR_W-1:0] reg_rd_addr_o,
    input  logic [31:0]       reg_rd_data_i,
    output logic              reg_wr_en_o,
    output logic [ADDR_W-1:0] reg_wr_addr_o,
    output logic [31:0]       reg_wr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        code_o
);
    localparam int TOT_W = ((BCNT_W > LEN_W) ? BCNT_W : LEN_W) + 1;
    localparam int TCW   = $clog2(TMO_CYC + 1) + 1;

    tx_state_t         state_q, state_d;
    logic [15:0]       vid_q;
    logic [7:0]        type_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [TOT_W-1:0]  idx_q;
    logic              done_q;
    tx_code_t          code_q;

    logic [TOT_W-1:0]  pay_dw;
    logic [LEN_W-1:0]  len_field;
    logic              too_big;
    logic [1:0]        tail;
    logic [31:0]       buf_rdata;
    logic [TCW-1:0]    elapsed;
    logic              expired;
    logic              fin;
    tx_code_t          fin_code;
    logic              last_pay;

    mbx_len_calc #(.BCNT_W(BCNT_W), .LEN_W(LEN_W), .TOT_W(TOT_W)) i_len (
        .nbytes   (bcnt_q),
        .pay_dw   (pay_dw),
        .len_field(len_field),
        .too_big  (too_big),
        .tail     (tail)
    );

    mbx_pay_buf #(.DEPTH(BUF_DW), .AW(BUF_AW)) i_buf (
        .clk  (clk),
        .we   (pbuf_we_i),
        .waddr(pbuf_addr_i),
        .wdata(pbuf_data_i),
        .raddr(idx_q[BUF_AW-1:0]),
        .rdata(buf_rdata)
    );

    mbx_elapsed #(.TMO_CYC(TMO_CYC), .CW(TCW)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_IDLE),
        .en     (state_q == ST_POLL_RD || state_q == ST_POLL_CHK),
        .cnt    (elapsed),
        .expired(expired)
    );

    assign last_pay = (idx_q + TOT_W'(1)) == pay_dw;

    // Next state and end-of-sequence result.
    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_code = RC_OK;
        case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_POLL_RD;
            ST_POLL_RD:  state_d = ST_POLL_CHK;
            ST_POLL_CHK: begin
                if (reg_rd_data_i[BUSY_BIT]) begin
                    if (expired) begin
                        state_d = ST_IDLE; fin = 1'b1; fin_code = RC_BUSY;
                    end else begin
                        state_d = ST_POLL_RD;
                    end
                end else if (reg_rd_data_i[ERR_BIT]) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_code = RC_IOERR;
                end else if (too_big) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_code = RC_TOOBIG;
                end else begin
                    state_d = ST_HDR1;
                end
            end
            ST_HDR1:     state_d = ST_HDR2;
            ST_HDR2:     state_d = (pay_dw == '0) ? ST_GO : ST_PAY;
            ST_PAY:      if (last_pay) state_d = ST_GO;
            ST_GO: begin
                state_d = ST_IDLE; fin = 1'b1; fin_code = RC_OK;
            end
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, captured request and payload index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vid_q   <= '0;
            type_q  <= '0;
            bcnt_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                vid_q  <= vendor_i;
                type_q <= objtype_i;
                bcnt_q <= nbytes_i;
            end
            if (state_q == ST_HDR2)     idx_q <= '0;
            else if (state_q == ST_PAY) idx_q <= idx_q + TOT_W'(1);
        end
    end

    // Registered completion pulse and result code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            code_q <= RC_OK;
        end else begin
            done_q <= fin;
            if (fin) code_q <= fin_code;
        end
    end

    // Register port drive, decoded from the current state.
    always_comb begin
        reg_rd_en_o   = (state_q == ST_POLL_RD);
        reg_rd_addr_o = reg_rd_en_o ? ADDR_STAT : '0;
        reg_wr_en_o   = 1'b0;
        reg_wr_addr_o = '0;
        reg_wr_data_o = '0;
        case (state_q)
            ST_HDR1: begin
                reg_wr_en_o   = 1'b1;
                reg_wr_addr_o = ADDR_WMB;
                reg_wr_data_o = {8'h00, type_q, vid_q};
            end
            ST_HDR2: begin
                reg_wr_en_o   = 1'b1;
                reg_wr_addr_o = ADDR_WMB;
                reg_wr_data_o = 32'(len_field);
            end
            ST_PAY: begin
                reg_wr_en_o   = 1'b1;
                reg_wr_addr_o = ADDR_WMB;
                reg_wr_data_o = last_pay ? pad_tail(buf_rdata, tail) : buf_rdata;
            end
            ST_GO: begin
                reg_wr_en_o   = 1'b1;
                reg_wr_addr_o = ADDR_CTRL;
                reg_wr_data_o = 32'h1 << GO_BIT;
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign code_o = code_q;

    // R13: one register access per cycle.
    a_r13_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en_o && reg_wr_en_o));

    // R11: completion is a one-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: the control write is followed by a successful completion.
    a_r10_go_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en_o && reg_wr_addr_o == ADDR_CTRL) |=> (done_o && code_o == RC_OK));

    // R2: the first header goes out only after a clean idle status read.
    a_r2_send_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR1) |->
            $past(state_q == ST_POLL_CHK && !reg_rd_data_i[BUSY_BIT] && !reg_rd_data_i[ERR_BIT]));

    // R3: a busy-timeout result needs the full timeout to have elapsed.
    a_r3_timeout_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && fin_code == RC_BUSY) |-> elapsed >= TCW'(TMO_CYC));

endmodule

// File: tb/test_mbx_req_sender.sv
module test_mbx_req_sender;
    localparam int BCNT_W = 6;
    localparam int LEN_W  = 3;
    localparam int BUF_DW = 8;
    localparam int TMO    = 20;
    localparam int MAXDW  = 1 << LEN_W;
    localparam logic [11:0] A_CTRL = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;
    localparam logic [11:0] A_WMB  = 12'h010;

    logic clk = 0, rst_n = 0;
    logic start = 0;
    logic [15:0] vid = '0;
    logic [7:0] typ = '0;
    logic [BCNT_W-1:0] nb = '0;
    logic pwe = 0;
    logic [2:0] paddr = '0;
    logic [31:0] pdata = '0;
    logic rd_en, wr_en, busy, done;
    logic [11:0] rd_addr, wr_addr;
    logic [31:0] rd_data = '0, wr_data;
    logic [1:0] code;

    int errors = 0, checks = 0;
    int mb_busy_n = 0;
    bit mb_forever = 0, mb_err = 0;
    int rd_seen = 0;
    int ncyc = 0;
    int lg_n = 0;
    logic [11:0] lg_a [0:1023];
    logic [31:0] lg_d [0:1023];
    int lg_c [0:1023];

    always #5 clk = ~clk;

    mbx_req_sender #(.BCNT_W(BCNT_W), .LEN_W(LEN_W), .BUF_DW(BUF_DW), .TMO_CYC(TMO))
    i_mbx_req_sender (
        .clk(clk), .rst_n(rst_n), .start_i(start), .vendor_i(vid), .objtype_i(typ),
        .nbytes_i(nb), .pbuf_we_i(pwe), .pbuf_addr_i(paddr), .pbuf_data_i(pdata),
        .reg_rd_en_o(rd_en), .reg_rd_addr_o(rd_addr), .reg_rd_data_i(rd_data),
        .reg_wr_en_o(wr_en), .reg_wr_addr_o(wr_addr), .reg_wr_data_o(wr_data),
        .busy_o(busy), .done_o(done), .code_o(code)
    );

    // Mailbox status model: answers a read one cycle later.
    always @(posedge clk) begin
        if (start && !busy) rd_seen <= 0;
        else if (rd_en) begin
            rd_data <= {29'h0, mb_err, 1'b0, (mb_forever || rd_seen < mb_busy_n)};
            rd_seen <= rd_seen + 1;
        end
    end

    // Write logger and cycle counter, sampled at the falling edge.
    always @(negedge clk) begin
        ncyc <= ncyc + 1;
        if (wr_en && lg_n < 1024) begin
            lg_a[lg_n] <= wr_addr;
            lg_d[lg_n] <= wr_data;
            lg_c[lg_n] <= ncyc;
            lg_n <= lg_n + 1;
        end
    end

    function automatic logic [31:0] pat(input int i, input int s);
        logic [7:0] b;
        b = 8'(i + 16 * s);
        return {8'h80 + b, 8'h40 + b, 8'h20 + b, 8'h10 + b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input int s);
        for (int i = 0; i < BUF_DW; i++) begin
            @(negedge clk);
            pwe = 1; paddr = 3'(i); pdata = pat(i, s);
        end
        @(negedge clk);
        pwe = 0;
    endtask

    task automatic run_req(input int b, input logic [15:0] v, input logic [7:0] t,
                           input int bn, input bit fb, input bit er, input int s,
                           input bit restart, input bit timing);
        int base, cyc, pd, tot, expc, tl, nw, dcyc;
        logic [31:0] e;
        pd = (b + 3) / 4;
        tot = 2 + pd;
        expc = fb ? 1 : (er ? 2 : (tot > MAXDW ? 3 : 0));
        tl = b % 4;
        mb_busy_n = bn; mb_forever = fb; mb_err = er;
        @(negedge clk);
        base = lg_n;
        nb = BCNT_W'(b); vid = v; typ = t; start = 1;
        @(negedge clk);
        start = 0;
        cyc = 1;
        if (restart) begin
            repeat (4) @(negedge clk);
            cyc += 4;
            nb = 6'd1; vid = 16'hDEAD; typ = 8'hEE; start = 1;
            @(negedge clk);
            cyc++;
            start = 0;
        end
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        dcyc = ncyc;
        chk(done == 1, "R11 done seen", 32'(done), 1);
        chk(code == 2'(expc), (expc == 1) ? "R3 code" : (expc == 2) ? "R4 code" :
            (expc == 3) ? "R5 code" : "R11 code", 32'(code), 32'(expc));
        nw = lg_n - base;
        if (expc != 0) begin
            chk(nw == 0, "R2 no write on failure", 32'(nw), 0);
        end else begin
            chk(nw == tot + 1, "R8 write count", 32'(nw), 32'(tot + 1));
            if (nw == tot + 1) begin
                chk(lg_a[base] == A_WMB && lg_d[base] == {8'h0, t, v}, "R6 header1",
                    lg_d[base], {8'h0, t, v});
                e = 32'(tot % MAXDW);
                chk(lg_a[base+1] == A_WMB && lg_d[base+1] == e, "R7 header2", lg_d[base+1], e);
                for (int i = 0; i < pd; i++) begin
                    e = pat(i % BUF_DW, s);
                    if (i == pd - 1 && tl != 0) begin
                        e = e & ((32'h1 << (8 * tl)) - 1);
                        chk(lg_d[base+2+i] == e, "R9 padded tail", lg_d[base+2+i], e);
                    end else
                        chk(lg_d[base+2+i] == e, "R8 payload", lg_d[base+2+i], e);
                    chk(lg_a[base+2+i] == A_WMB, "R8 payload address", 32'(lg_a[base+2+i]), 32'(A_WMB));
                end
                chk(lg_a[base+tot] == A_CTRL && lg_d[base+tot] == 32'h8000_0000, "R10 go write",
                    lg_d[base+tot], 32'h8000_0000);
                chk(dcyc == lg_c[base+tot] + 1, "R11 done after go", 32'(dcyc), 32'(lg_c[base+tot] + 1));
            end
        end
        if (timing)
            chk(cyc >= TMO && cyc <= TMO + 3, "R3 timeout window", 32'(cyc), 32'(TMO));
        @(negedge clk);
        chk(done == 0, "R11 single pulse", 32'(done), 0);
        chk(busy == 0, "R12 idle after end", 32'(busy), 0);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_up();
    end

    // One status read must never share a cycle with a write (R13).
    always @(negedge clk) if (rst_n && rd_en && wr_en) begin
        errors++;
        $display("FAIL R13 read and write together actual=1 expected=0");
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1 reset state",
            {28'h0, busy, done, rd_en, wr_en}, 0);
        fill(0);
        for (int b = 0; b <= 40; b++)
            run_req(b, 16'h1E0F + 16'(b), 8'(b + 3), 0, 0, 0, 0, 0, 0);
        fill(1);
        for (int b = 0; b <= 24; b += 3)
            run_req(b, 16'hA5C3, 8'h7D, 0, 0, 0, 1, 0, 0);
        run_req(5, 16'h0001, 8'h02, 3, 0, 0, 1, 0, 0);   // R2 busy then clear
        run_req(13, 16'h0001, 8'h02, 2, 0, 1, 1, 0, 0);  // R4 error
        run_req(40, 16'h0001, 8'h02, 0, 0, 1, 1, 0, 0);  // R4 before R5
        run_req(40, 16'h0001, 8'h02, 2, 0, 0, 1, 0, 0);  // R5 after busy
        run_req(5, 16'h0001, 8'h02, 0, 1, 0, 1, 0, 1);   // R3 timeout
        run_req(40, 16'h0001, 8'h02, 0, 1, 1, 1, 0, 1);  // R3 before R4/R5
        run_req(22, 16'h3C3C, 8'h44, 1, 0, 0, 1, 1, 0);  // R12 restart ignored
        finish_up();
    end
endmodule